// File: doc/BRIEF.md
# Interrupt Priority Resolver with Vectors

This block takes twelve interrupt request lines and picks one winner per clock cycle. The sources are two external interrupts, two timer overflows and eight extra external interrupts. A request is a candidate only when three things are set: its pending flag, its own enable and the global enable. A source programmed as high priority always beats a low-priority source. Among sources of the same level, a fixed interleaved polling order decides. The winner's identifier, its 16-bit vector address and its priority level are registered together with a valid strobe.

Each source is either edge-triggered or level-triggered. An edge-triggered source latches a rising edge into a pending flag, and acknowledging that source as the winner clears the flag. A level-triggered source is pending for as long as its input is high, and an acknowledge does not clear it. Acknowledging the winner puts its priority level into service. While a level is in service, no source of that level or any lower level is offered. A high-priority source may still interrupt a low-priority one that is in service. A service-done pulse ends the most recently entered level.

Top module: `irq_resolver`

## Requirements
- R1: The vector for a source is fixed by its identifier: id 0 gives 0003h, id 1 gives 000Bh, id 2 gives 0013h and id 3 gives 001Bh. Ids 4 to 11 give 003Bh up to 0073h in steps of 8. Every valid vector therefore ends in the bits 011.
- R2: Among candidates of equal level, the winner is the first one in this id order: 0, 7, 1, 8, 2, 4, 9, 3, 5, 10, 6, 11. Id 0 always wins a tie. Id 11 wins only when it is alone.
- R3: A candidate whose hi_pri bit is 1 beats every candidate whose hi_pri bit is 0, wherever it sits in the polling order.
- R4: A source is a candidate only when its flag is set, its src_en bit is 1 and glb_en is 1. An edge flag latched while its source is disabled stays pending.
- R5: The outputs are registered. They reflect the inputs sampled at the previous rising edge. When there is no candidate, irq_valid is 0 and irq_id, irq_vec and irq_hi are all 0.
- R6: When trig_edge is 1, a 0-to-1 change of req_in sets the flag. The flag is cleared when ack is sampled while that source is the valid winner. A new edge in the same cycle wins over the clear.
- R7: When trig_edge is 0, the source is pending exactly while req_in is 1, and ack does not clear it.
- R8: When ack is sampled with irq_valid high, the winner's level enters service. While high is in service nothing is offered. While only low is in service, only high-priority candidates are offered.
- R9: A svc_done pulse ends high service if it is active, and otherwise ends low service. When both arrive together, svc_done is applied before the new acknowledge.
- R10: After reset, all flags are clear, no level is in service and irq_valid is 0.
- R11: An ack sampled while irq_valid is 0 changes neither the flags nor the service state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| glb_en | input | 1 | Global interrupt enable |
| src_en | input | 12 | Per-source enable, indexed by id |
| hi_pri | input | 12 | Per-source level, 1 = high |
| trig_edge | input | 12 | Per-source trigger, 1 = edge, 0 = level |
| req_in | input | 12 | Raw request lines, indexed by id |
| ack | input | 1 | Acknowledge of the current winner |
| svc_done | input | 1 | End of the innermost service level |
| irq_valid | output | 1 | A winner is offered |
| irq_id | output | 4 | Identifier of the winner |
| irq_vec | output | 16 | Vector address of the winner |
| irq_hi | output | 1 | The winner is high priority |

## Verification
Four properties are checked on every cycle:
- an idle output is all zeros;
- every valid vector ends in 011;
- an offered winner requires glb_en at the previous edge;
- the in-service state suppresses offers according to R8.

Only the bench's reference model can show the polling order, the exact vector per source, edge latching and clearing, level persistence and the nesting and unwinding of service. That model runs across directed scenarios and a randomized phase.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;
  localparam int NSRC  = 12;
  localparam int ID_W  = 4;
  localparam int VEC_W = 16;

  // Vector: the four base sources sit 8 apart from 0003h; the extra
  // sources continue from 003Bh, also 8 apart.
  function automatic logic [VEC_W-1:0] vec_of(input logic [ID_W-1:0] id);
    logic [VEC_W-1:0] step;
    step = {{(VEC_W-ID_W-3){1'b0}}, id, 3'b000};
    if (id < 4'd4) return 16'h0003 + step;
    else           return 16'h001B + step;
  endfunction

  // Source identifier polled at a given rank (rank 0 polled first).
  function automatic logic [ID_W-1:0] id_at_rank(input int r);
    case (r)
      0:  return 4'd0;
      1:  return 4'd7;
      2:  return 4'd1;
      3:  return 4'd8;
      4:  return 4'd2;
      5:  return 4'd4;
      6:  return 4'd9;
      7:  return 4'd3;
      8:  return 4'd5;
      9:  return 4'd10;
      10: return 4'd6;
      default: return 4'd11;
    endcase
  endfunction
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int N = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_in,
  input  logic [N-1:0] trig_edge,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag_nxt
);
  logic [N-1:0] req_prev_q;
  logic [N-1:0] eflag_q;
  logic [N-1:0] rise;

  assign rise = req_in & ~req_prev_q;

  for (genvar i = 0; i < N; i++) begin : g_src
    logic eflag_d;
    assign eflag_d     = (eflag_q[i] & ~clr[i]) | rise[i];
    assign flag_nxt[i] = trig_edge[i] ? eflag_d : req_in[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        req_prev_q[i] <= 1'b0;
        eflag_q[i]    <= 1'b0;
      end else begin
        req_prev_q[i] <= req_in[i];
        eflag_q[i]    <= trig_edge[i] ? eflag_d : 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_svc_track.sv
module irq_svc_track (
  input  logic clk,
  input  logic rst_n,
  input  logic svc_done,
  input  logic take,
  input  logic take_hi,
  output logic svc_hi_q,
  output logic svc_lo_q,
  output logic allow_hi,
  output logic allow_lo
);
  logic hi_nxt, lo_nxt;

  // svc_done unwinds the innermost level first, then a new take is applied.
  always_comb begin
    hi_nxt = (svc_hi_q & ~svc_done) | (take & take_hi);
    lo_nxt = (svc_lo_q & ~(svc_done & ~svc_hi_q)) | (take & ~take_hi);
  end

  assign allow_hi = ~hi_nxt;
  assign allow_lo = ~hi_nxt & ~lo_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      svc_hi_q <= 1'b0;
      svc_lo_q <= 1'b0;
    end else begin
      svc_hi_q <= hi_nxt;
      svc_lo_q <= lo_nxt;
    end
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_res_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic [N-1:0]    cand,
  input  logic [N-1:0]    hi_pri,
  output logic            found,
  output logic [ID_W-1:0] win_id,
  output logic            win_hi
);
  // Two passes over the polling order: the high level first, then the low.
  always_comb begin
    found  = 1'b0;
    win_id = '0;
    win_hi = 1'b0;
    for (int lvl = 1; lvl >= 0; lvl--) begin
      for (int r = 0; r < N; r++) begin
        logic [ID_W-1:0] s;
        s = id_at_rank(r);
        if (!found && cand[s] && (hi_pri[s] == lvl[0])) begin
          found  = 1'b1;
          win_id = s;
          win_hi = lvl[0];
        end
      end
    end
  end
endmodule

// File: rtl/irq_resolver.sv
module irq_resolver
  import irq_res_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             glb_en,
  input  logic [NSRC-1:0]  src_en,
  input  logic [NSRC-1:0]  hi_pri,
  input  logic [NSRC-1:0]  trig_edge,
  input  logic [NSRC-1:0]  req_in,
  input  logic             ack,
  input  logic             svc_done,
  output logic             irq_valid,
  output logic [ID_W-1:0]  irq_id,
  output logic [VEC_W-1:0] irq_vec,
  output logic             irq_hi
);
  logic [NSRC-1:0] flag_nxt, clr, cand;
  logic            ack_take;
  logic            svc_hi_q, svc_lo_q, allow_hi, allow_lo;
  logic            found, pick_hi;
  logic [ID_W-1:0] pick_id;

  assign ack_take = ack & irq_valid;

  for (genvar i = 0; i < NSRC; i++) begin : g_clr
    assign clr[i]  = ack_take && (irq_id == i[ID_W-1:0]);
    assign cand[i] = flag_nxt[i] & src_en[i] & glb_en &
                     (hi_pri[i] ? allow_hi : allow_lo);
  end

  irq_flag_bank #(.N(NSRC)) u_flags (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .trig_edge(trig_edge),
    .clr(clr), .flag_nxt(flag_nxt)
  );

  irq_svc_track u_svc (
    .clk(clk), .rst_n(rst_n), .svc_done(svc_done), .take(ack_take),
    .take_hi(irq_hi), .svc_hi_q(svc_hi_q), .svc_lo_q(svc_lo_q),
    .allow_hi(allow_hi), .allow_lo(allow_lo)
  );

  irq_pick #(.N(NSRC)) u_pick (
    .cand(cand), .hi_pri(hi_pri), .found(found), .win_id(pick_id),
    .win_hi(pick_hi)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_valid <= 1'b0;
      irq_id    <= '0;
      irq_vec   <= '0;
      irq_hi    <= 1'b0;
    end else begin
      irq_valid <= found;
      irq_id    <= found ? pick_id : '0;
      irq_vec   <= found ? vec_of(pick_id) : '0;
      irq_hi    <= found & pick_hi;
    end
  end
endmodule

// File: rtl/irq_res_chk.sv
module irq_res_chk
  import irq_res_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             glb_en,
  input logic             irq_valid,
  input logic [ID_W-1:0]  irq_id,
  input logic [VEC_W-1:0] irq_vec,
  input logic             irq_hi,
  input logic             svc_hi_q,
  input logic             svc_lo_q
);
  // R5
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_valid |-> (irq_vec == '0 && irq_id == '0 && !irq_hi));
  // R1
  vec_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_vec[2:0] == 3'b011));
  // R4
  glb_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> $past(glb_en));
  // R8
  hi_svc_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc_hi_q |-> !irq_valid);
  // R8
  lo_svc_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_lo_q && irq_valid) |-> irq_hi);
endmodule

bind irq_resolver irq_res_chk u_chk (
  .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .irq_valid(irq_valid),
  .irq_id(irq_id), .irq_vec(irq_vec), .irq_hi(irq_hi),
  .svc_hi_q(svc_hi_q), .svc_lo_q(svc_lo_q)
);

// File: tb/irq_resolver_bench.sv
`timescale 1ns/1ps
module irq_resolver_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        glb_en = 1'b0, ack = 1'b0, svc_done = 1'b0;
  logic [11:0] src_en = '0, hi_pri = '0, trig_edge = '0, req_in = '0;
  logic        irq_valid, irq_hi;
  logic [3:0]  irq_id;
  logic [15:0] irq_vec;

  int checks = 0, failures = 0;
  string cur_req = "R10";
  bit done = 0;

  always #2 clk = ~clk;

  irq_resolver u_irq_resolver (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .src_en(src_en),
    .hi_pri(hi_pri), .trig_edge(trig_edge), .req_in(req_in), .ack(ack),
    .svc_done(svc_done), .irq_valid(irq_valid), .irq_id(irq_id),
    .irq_vec(irq_vec), .irq_hi(irq_hi)
  );

  // Reference model
  int  poll [12] = '{0, 7, 1, 8, 2, 4, 9, 3, 5, 10, 6, 11};
  int  vtab [12] = '{'h03, 'h0B, 'h13, 'h1B, 'h3B, 'h43, 'h4B, 'h53,
                     'h5B, 'h63, 'h6B, 'h73};
  bit  m_prev [12];
  bit  m_eflag [12];
  bit  m_valid = 0, m_hi = 0;
  int  m_id = 0;
  bit  m_lvls [$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_prev[i]) begin m_prev[i] = 0; m_eflag[i] = 0; end
      m_valid = 0; m_hi = 0; m_id = 0;
      m_lvls.delete();
    end else begin
      bit pend [12];
      bit took, took_hi, may_hi, may_lo, nv, nh;
      int nid;
      took = ack && m_valid;
      took_hi = m_hi;
      for (int i = 0; i < 12; i++) begin
        bit rise;
        rise = req_in[i] && !m_prev[i];
        if (took && m_id == i) m_eflag[i] = 0;
        if (rise) m_eflag[i] = 1;
        if (!trig_edge[i]) m_eflag[i] = 0;
        pend[i] = trig_edge[i] ? m_eflag[i] : req_in[i];
        m_prev[i] = req_in[i];
      end
      if (svc_done && m_lvls.size() > 0) void'(m_lvls.pop_back());
      if (took) m_lvls.push_back(took_hi);
      may_hi = (m_lvls.size() == 0) || (m_lvls[$] == 0);
      may_lo = (m_lvls.size() == 0);
      nv = 0; nh = 0; nid = 0;
      for (int pass = 0; pass < 2; pass++) begin
        for (int k = 0; k < 12; k++) begin
          int s;
          bit want_hi;
          s = poll[k];
          want_hi = (pass == 0);
          if (!nv && pend[s] && src_en[s] && glb_en && (hi_pri[s] == want_hi)
              && (want_hi ? may_hi : may_lo)) begin
            nv = 1; nid = s; nh = want_hi;
          end
        end
      end
      m_valid = nv; m_id = nid; m_hi = nh;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int ev, eid, eh;
      ev  = m_valid;
      eid = m_valid ? m_id : 0;
      eh  = m_valid ? m_hi : 0;
      checks++;
      if (irq_valid !== ev[0] || irq_id !== eid[3:0] || irq_hi !== eh[0] ||
          irq_vec !== (m_valid ? vtab[m_id][15:0] : 16'h0)) begin
        failures++;
        $display("FAIL %s: got v=%0b id=%0d vec=%h hi=%0b exp v=%0d id=%0d vec=%h hi=%0d",
                 cur_req, irq_valid, irq_id, irq_vec, irq_hi, ev, eid,
                 m_valid ? vtab[m_id] : 0, eh);
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_ack();
    ack = 1; cyc(1); ack = 0;
  endtask

  task automatic pulse_done();
    svc_done = 1; cyc(1); svc_done = 0;
  endtask

  task automatic clean();
    req_in = '0; glb_en = 1; src_en = '1;
    ack = 1; svc_done = 1; cyc(14);
    ack = 0; cyc(2); svc_done = 0; cyc(1);
    hi_pri = '0;
  endtask

  initial begin
    cyc(3); rst_n = 1;
    cur_req = "R10"; cyc(2);

    // R1: each source alone, level mode
    cur_req = "R1";
    glb_en = 1; trig_edge = '0; hi_pri = '0;
    for (int i = 0; i < 12; i++) begin
      src_en = 12'(1 << i); req_in = 12'(1 << i);
      cyc(2);
      if (irq_vec !== vtab[i][15:0]) begin
        failures++;
        $display("FAIL R1: vec %h exp %h", irq_vec, vtab[i]);
      end
      checks++;
      clean();
    end

    // R2: all edge sources at once, drain in polling order
    cur_req = "R2";
    trig_edge = '1; src_en = '1;
    req_in = '1; cyc(1); req_in = '0;
    for (int k = 0; k < 12; k++) begin
      cyc(1);
      if (irq_id !== poll[k][3:0]) begin
        failures++;
        $display("FAIL R2: id %0d exp %0d", irq_id, poll[k]);
      end
      checks++;
      pulse_ack(); pulse_done();
    end
    clean();

    // R3: high priority on the last-polled source
    cur_req = "R3";
    trig_edge = '0; hi_pri = 12'h800; req_in = '1; cyc(3);
    hi_pri = 12'h808; cyc(3);
    clean();

    // R4: global and per-source gating
    cur_req = "R4";
    trig_edge = 12'h0F0; glb_en = 0; req_in = 12'h0FF; cyc(3);
    glb_en = 1; src_en = 12'h0F0; cyc(3);
    req_in = '0; src_en = 12'h0F3; cyc(3);
    src_en = '1; cyc(2);
    clean();

    // R6 / R7: edge clears on ack, level persists
    cur_req = "R6";
    trig_edge = 12'h001; req_in = 12'h001; cyc(1); req_in = 0; cyc(2);
    pulse_ack(); cyc(2); pulse_done(); cyc(2);
    req_in = 12'h001; cyc(1); ack = 1; req_in = 0; cyc(1);
    req_in = 1; ack = 0; cyc(2); clean();
    cur_req = "R7";
    trig_edge = '0; req_in = 12'h002; cyc(2);
    pulse_ack(); cyc(2); pulse_done(); cyc(3);
    req_in = 0; cyc(2); clean();

    // R8 / R9: nesting
    cur_req = "R8";
    trig_edge = '0; req_in = 12'h002; cyc(2);
    pulse_ack(); req_in = 12'h003; cyc(3);
    hi_pri = 12'h800; req_in = 12'h803; cyc(2);
    pulse_ack(); cyc(2);
    cur_req = "R9";
    pulse_done(); cyc(2);
    req_in = 12'h003; cyc(2);
    pulse_done(); cyc(2);
    svc_done = 1; ack = 1; cyc(1); svc_done = 0; ack = 0; cyc(2);
    clean();

    // R11: ack while idle
    cur_req = "R11";
    req_in = '0; pulse_ack(); cyc(1);
    trig_edge = '0; req_in = 12'h010; cyc(3);
    clean();

    // R5: randomized mix
    cur_req = "R5";
    for (int n = 0; n < 3000; n++) begin
      if (n % 50 == 0) begin
        trig_edge = 12'($urandom); hi_pri = 12'($urandom);
        src_en = 12'($urandom) | 12'($urandom);
      end
      req_in   = 12'($urandom) & 12'($urandom);
      glb_en   = ($urandom % 8) != 0;
      ack      = ($urandom % 4) == 0;
      svc_done = ($urandom % 5) == 0;
      cyc(1);
    end
    ack = 0; svc_done = 0; cyc(2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog: run did not complete, exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule